// File: doc/BRIEF.md
# Multidrop Serial Port with Ninth-Bit Address Filtering

This block is a serial port with a single control byte and one data buffer. It has four operating modes. Mode 0 is a synchronous shifter: eight bits go out or come in on a bidirectional data line, and the clock pin drives a shift clock at one twelfth of the system clock. Modes 1 to 3 are asynchronous. Each frame has a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. The bit time is always sixteen serial ticks. In mode 2 those ticks come from a fixed divider of the system clock. In modes 1 and 3 they come from an overflow pulse produced by a timer outside the block.

Software starts a transmission by writing the data buffer. It sets up the mode, the receive enable and the ninth transmit bit by writing the control byte. The block raises a transmit-done flag at the end of a frame and a receive-done flag when it accepts a frame. Both flags stay set until software writes the control byte again.

In the nine-bit modes an address mask bit makes the receiver drop every frame whose ninth bit is 0. A node on a multidrop line can therefore sleep through data frames meant for other nodes and wake only on address frames.

Top module: `msp_serial`

## Requirements
- R1: After reset, `ctl_rdata` is 0x00, `rx_buf` is 0x00, `txd` is 1 and `rxd_oe` is 0.
- R2: A write on `ctl_wr` loads the whole control byte, and `ctl_rdata` returns it. The bit fields are: [1:0] mode, [2] address mask, [3] receive enable, [4] transmit ninth bit, [5] received ninth bit, [6] transmit done, [7] receive done.
- R3: In mode 0, a buffer write shifts the byte out on `rxd_out` least significant bit first, with `rxd_oe` high. `txd` is low for 6 and high for 6 system clocks per bit, each bit is valid at the rising edge of `txd`, and transmit done is set after the eighth bit.
- R4: In mode 0, when receive enable is 1 and receive done is 0, the port clocks eight bits in from `rxd_in`. Each bit is sampled at a rising edge of `txd`, least significant bit first. The byte goes to `rx_buf` and receive done is set.
- R5: In modes 1 to 3, a buffer write sends a start bit 0, eight data bits least significant bit first, then the transmit ninth bit in modes 2 and 3 only, then a stop bit 1. Transmit done is set at the end of the stop bit.
- R6: In mode 2 a bit lasts 32 system clocks when `rate_dbl` is 1 and 64 when it is 0.
- R7: In modes 1 and 3 a bit lasts 16 serial ticks. A tick is every `ovf_pulse` when `rate_dbl` is 1 and every second `ovf_pulse` when it is 0.
- R8: An accepted asynchronous frame puts its data in `rx_buf` and sets receive done. The received ninth bit takes the frame's ninth bit in modes 2 and 3 and the stop bit in mode 1.
- R9: In modes 2 and 3 with the mask bit set, a frame whose ninth bit is 0 leaves `rx_buf` and the flags unchanged, and a frame whose ninth bit is 1 is accepted.
- R10: In mode 1 with the mask bit set, a frame whose stop bit is 0 is dropped. With the mask clear, the same frame is accepted.
- R11: While receive enable is 0, incoming frames change neither `rx_buf` nor receive done.
- R12: While receive done is 1, a new incoming frame is dropped and `rx_buf` and the received ninth bit are kept.
- R13: Each received bit is the majority of three samples taken at ticks 7, 8 and 9 of its 16. A start bit that votes 1 is abandoned and yields no frame.
- R14: The transmit-done and receive-done flags stay set until a control write clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_pulse | input | 1 | One-cycle overflow pulse from the external rate timer |
| rate_dbl | input | 1 | Rate-double select |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rdata | output | 8 | Current control byte |
| buf_wr | input | 1 | Data buffer write strobe, starts a transmission |
| buf_wdata | input | 8 | Byte to transmit |
| rx_buf | output | 8 | Last accepted received byte |
| rxd_in | input | 1 | Serial data in (async line, or mode 0 data in) |
| rxd_out | output | 1 | Mode 0 data out |
| rxd_oe | output | 1 | Mode 0 data output enable |
| txd | output | 1 | Async transmit line, or mode 0 shift clock |

## Verification
The hardest cases to reach from the ports are the receiver's drop paths. These are a masked frame with ninth bit 0, a mode 1 frame whose stop bit is low, a frame arriving while receive done is still set, and a false start. Each one must leave `rx_buf` and the flags untouched. To make them visible, the bench first loads a known byte into `rx_buf`. It then drives `rxd_in` with bit-timed frames that have a chosen ninth bit or stop bit, or with a low glitch shorter than the sample window, and checks afterwards that the known byte is still there. A valid frame sent next confirms that the receiver has gone back to idle.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC   = 2'd0,
    MODE_A8_VAR = 2'd1,
    MODE_A9_FIX = 2'd2,
    MODE_A9_VAR = 2'd3
  } sp_mode_e;

  typedef struct packed {
    logic     rx_done;
    logic     tx_done;
    logic     rx_b8;
    logic     tx_b8;
    logic     rx_en;
    logic     mask;
    sp_mode_e mode;
  } sp_ctl_t;
endpackage

// File: rtl/msp_rate_gen.sv
module msp_rate_gen
  import msp_pkg::*;
#(
  parameter int FIX_FAST = 2,
  parameter int FIX_SLOW = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     ovf,
  input  logic     rate_dbl,
  output logic     tick
);
  localparam int CW = $clog2(FIX_SLOW);

  logic [CW-1:0] div_q, div_d, lim;
  logic          half_q, half_d, tick_q, tick_d;
  logic          is_var;

  assign is_var = (mode == MODE_A8_VAR) || (mode == MODE_A9_VAR);
  assign lim    = rate_dbl ? CW'(FIX_FAST - 1) : CW'(FIX_SLOW - 1);

  always_comb begin
    div_d  = '0;
    half_d = half_q;
    tick_d = 1'b0;
    if (mode == MODE_A9_FIX) begin
      if (div_q >= lim) begin
        tick_d = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end else if (is_var && ovf) begin
      if (rate_dbl) begin
        tick_d = 1'b1;
      end else begin
        half_d = ~half_q;
        tick_d = half_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      half_q <= half_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6
  fix_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_A9_FIX) |=> (!tick || mode != MODE_A9_FIX));

  // R7
  var_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_var) && tick) |-> $past(ovf));
endmodule

// File: rtl/msp_async_tx.sv
module msp_async_tx #(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          nine,
  input  logic          b8,
  input  logic [DW-1:0] data,
  input  logic          tick,
  output logic          line,
  output logic          done
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);
  localparam int CW = $clog2(TPB);

  logic [FW-1:0] frm_q, frm_d;
  logic [IW-1:0] idx_q, idx_d, last_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;

  assign last_idx = nine ? IW'(FW - 1) : IW'(FW - 2);

  always_comb begin
    frm_d  = frm_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        frm_d  = {1'b1, (nine ? b8 : 1'b1), data, 1'b0};
        idx_d  = '0;
        cnt_d  = '0;
        busy_d = 1'b1;
      end
    end else if (tick) begin
      if (cnt_q == CW'(TPB - 1)) begin
        cnt_d = '0;
        if (idx_q == last_idx) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          frm_d = {1'b1, frm_q[FW-1:1]};
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      frm_q  <= frm_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign line = busy_q ? frm_q[0] : 1'b1;
  assign done = done_q;

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(line));
endmodule

// File: rtl/msp_async_rx.sv
module msp_async_rx #(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  input  logic          tick,
  output logic          fv,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          stop
);
  localparam int IW  = $clog2(DW + 3);
  localparam int CW  = $clog2(TPB);
  localparam int MID = TPB / 2 - 1;

  logic          s1_q, s2_q, prev_q;
  logic          busy_q, busy_d, fv_q, fv_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    smp_q, smp_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          b9_q, b9_d, stop_q, stop_d, vote;

  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & s2_q) | (smp_q[1] & s2_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    smp_d  = smp_q;
    sh_d   = sh_q;
    b9_d   = b9_q;
    stop_d = stop_q;
    fv_d   = 1'b0;
    if (!busy_q) begin
      if (en && prev_q && !s2_q) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        idx_d  = '0;
      end
    end else if (tick) begin
      if (cnt_q == CW'(TPB - 1)) begin
        cnt_d = '0;
        idx_d = idx_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (cnt_q == CW'(MID))     smp_d[0] = s2_q;
      if (cnt_q == CW'(MID + 1)) smp_d[1] = s2_q;
      if (cnt_q == CW'(MID + 2)) begin
        if (idx_q == '0) begin
          if (vote) busy_d = 1'b0;
        end else if (idx_q <= IW'(DW)) begin
          sh_d = {vote, sh_q[DW-1:1]};
        end else if (idx_q == IW'(DW + 1) && nine) begin
          b9_d = vote;
        end else begin
          stop_d = vote;
          fv_d   = 1'b1;
          busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      smp_q  <= '0;
      sh_q   <= '0;
      b9_q   <= 1'b0;
      stop_q <= 1'b0;
      fv_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      smp_q  <= smp_d;
      sh_q   <= sh_d;
      b9_q   <= b9_d;
      stop_q <= stop_d;
      fv_q   <= fv_d;
    end
  end

  assign fv   = fv_q;
  assign data = sh_q;
  assign b9   = b9_q;
  assign stop = stop_q;

  // R13
  frame_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fv |-> !busy_q);

  // R11
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(busy_q)) |-> !busy_q);
endmodule

// File: rtl/msp_sync_shift.sv
module msp_sync_shift #(
  parameter int DW  = 8,
  parameter int DIV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic          rx_start,
  input  logic [DW-1:0] data,
  input  logic          rxd_in,
  output logic          sclk,
  output logic          dout,
  output logic          oe,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data
);
  localparam int PW   = $clog2(DIV);
  localparam int NW   = $clog2(DW);
  localparam int HALF = DIV / 2;

  logic          busy_q, busy_d, dir_q, dir_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [NW-1:0] n_q, n_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          txd_q, txd_d, rxd_q, rxd_d;

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    ph_d   = ph_q;
    n_d    = n_q;
    sh_d   = sh_q;
    txd_d  = 1'b0;
    rxd_d  = 1'b0;
    if (!busy_q) begin
      if (tx_start) begin
        busy_d = 1'b1;
        dir_d  = 1'b1;
        sh_d   = data;
        ph_d   = '0;
        n_d    = '0;
      end else if (rx_start) begin
        busy_d = 1'b1;
        dir_d  = 1'b0;
        ph_d   = '0;
        n_d    = '0;
      end
    end else begin
      if (!dir_q && ph_q == PW'(HALF - 1)) sh_d = {rxd_in, sh_q[DW-1:1]};
      if (ph_q == PW'(DIV - 1)) begin
        ph_d = '0;
        if (dir_q) sh_d = {1'b1, sh_q[DW-1:1]};
        if (n_q == NW'(DW - 1)) begin
          busy_d = 1'b0;
          txd_d  = dir_q;
          rxd_d  = ~dir_q;
        end else begin
          n_d = n_q + 1'b1;
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      ph_q   <= '0;
      n_q    <= '0;
      sh_q   <= '0;
      txd_q  <= 1'b0;
      rxd_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      ph_q   <= ph_d;
      n_q    <= n_d;
      sh_q   <= sh_d;
      txd_q  <= txd_d;
      rxd_q  <= rxd_d;
    end
  end

  assign sclk    = busy_q ? (ph_q >= PW'(HALF)) : 1'b1;
  assign dout    = sh_q[0];
  assign oe      = busy_q && dir_q;
  assign tx_done = txd_q;
  assign rx_done = rxd_q;
  assign rx_data = sh_q;

  // R3
  tx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && ph_q != '0) |-> $stable(dout));
endmodule

// File: rtl/msp_serial.sv
module msp_serial
  import msp_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TPB      = 16,
  parameter int SYNC_DIV = 12,
  parameter int FIX_FAST = 2,
  parameter int FIX_SLOW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf_pulse,
  input  logic          rate_dbl,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic [DW-1:0] rx_buf,
  input  logic          rxd_in,
  output logic          rxd_out,
  output logic          rxd_oe,
  output logic          txd
);
  logic          rs0_q, rs1_q, rst_n_s;
  sp_ctl_t       ctl_q, ctl_d;
  logic [DW-1:0] rxb_q, rxb_d;
  logic          is_sync, nine, tick;
  logic          a_line, a_done, a_fv, a_b9, a_stop, accept;
  logic [DW-1:0] a_data, s_rx_data;
  logic          s_sclk, s_dout, s_oe, s_tx_done, s_rx_done, s_rx_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_n_s = rs1_q;

  assign is_sync = (ctl_q.mode == MODE_SYNC);
  assign nine    = ctl_q.mode[1];

  msp_rate_gen #(.FIX_FAST(FIX_FAST), .FIX_SLOW(FIX_SLOW)) u_rate (
    .clk(clk), .rst_n(rst_n_s), .mode(ctl_q.mode), .ovf(ovf_pulse),
    .rate_dbl(rate_dbl), .tick(tick)
  );

  msp_async_tx #(.DW(DW), .TPB(TPB)) u_atx (
    .clk(clk), .rst_n(rst_n_s), .start(buf_wr && !is_sync), .nine(nine),
    .b8(ctl_q.tx_b8), .data(buf_wdata), .tick(tick), .line(a_line), .done(a_done)
  );

  msp_async_rx #(.DW(DW), .TPB(TPB)) u_arx (
    .clk(clk), .rst_n(rst_n_s), .en(ctl_q.rx_en && !is_sync), .nine(nine),
    .rxd(rxd_in), .tick(tick), .fv(a_fv), .data(a_data), .b9(a_b9), .stop(a_stop)
  );

  assign s_rx_start = is_sync && ctl_q.rx_en && !ctl_q.rx_done && !s_rx_done && !buf_wr;

  msp_sync_shift #(.DW(DW), .DIV(SYNC_DIV)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .tx_start(buf_wr && is_sync), .rx_start(s_rx_start),
    .data(buf_wdata), .rxd_in(rxd_in), .sclk(s_sclk), .dout(s_dout), .oe(s_oe),
    .tx_done(s_tx_done), .rx_done(s_rx_done), .rx_data(s_rx_data)
  );

  assign accept = a_fv && !is_sync && !ctl_q.rx_done &&
                  (!ctl_q.mask || (nine ? a_b9 : a_stop));

  always_comb begin
    ctl_d = ctl_q;
    rxb_d = rxb_q;
    if (ctl_wr) ctl_d = sp_ctl_t'(ctl_wdata);
    if (a_done || s_tx_done) ctl_d.tx_done = 1'b1;
    if (accept) begin
      ctl_d.rx_done = 1'b1;
      ctl_d.rx_b8   = nine ? a_b9 : a_stop;
      rxb_d         = a_data;
    end
    if (s_rx_done && !ctl_q.rx_done) begin
      ctl_d.rx_done = 1'b1;
      rxb_d         = s_rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q <= '0;
      rxb_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      rxb_q <= rxb_d;
    end
  end

  assign ctl_rdata = ctl_q;
  assign rx_buf    = rxb_q;
  assign txd       = is_sync ? s_sclk : a_line;
  assign rxd_out   = s_dout;
  assign rxd_oe    = s_oe;

  // R9
  mask_filter_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (a_fv && nine && ctl_q.mask && !a_b9 && !ctl_wr) |=> ($stable(rxb_q) && $stable(ctl_q.rx_done)));

  // R12
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (a_fv && ctl_q.rx_done && !ctl_wr) |=> ($stable(rxb_q) && $stable(ctl_q.rx_b8)));

  // R14
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(ctl_q.tx_done) && !$past(ctl_wr)) |-> ctl_q.tx_done);
endmodule

// File: tb/msp_serial_tb.sv
module msp_serial_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovf_pulse = 1'b0;
  logic       rate_dbl = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic [7:0] rx_buf;
  logic       rxd_in = 1'b1;
  logic       rxd_out, rxd_oe, txd;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  localparam int OVF_DIV = 4;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  msp_serial u_dut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .rate_dbl(rate_dbl),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_buf(rx_buf),
    .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd)
  );

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      ovf_pulse = (k == OVF_DIV - 1);
      k = (k == OVF_DIV - 1) ? 0 : k + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [1:0] m, input bit mask, input bit en, input bit tb8);
    return {3'b000, tb8, en, mask, m};
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wdata = v; buf_wr = 1'b1;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic wait_bit(input int b, input int lim);
    int w = 0;
    while (ctl_rdata[b] !== 1'b1 && w < lim) begin @(negedge clk); w++; end
  endtask

  task automatic wait_txd_rise();
    int w = 0;
    while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
    while (txd !== 1'b1 && w < 400) begin @(negedge clk); w++; end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has9, input bit b9,
                            input bit stopb, input int bitclk);
    @(negedge clk); rxd_in = 1'b0;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_in = d[i];
      repeat (bitclk) @(negedge clk);
    end
    if (has9) begin
      rxd_in = b9;
      repeat (bitclk) @(negedge clk);
    end
    rxd_in = stopb;
    repeat (bitclk) @(negedge clk);
    rxd_in = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
    chk(rx_buf == 8'h00, "R1 rx_buf", rx_buf, 0);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(rxd_oe == 1'b0, "R1 oe", rxd_oe, 0);
  endtask

  task automatic t_ctl();
    wr_ctl(8'h1E);
    chk(ctl_rdata == 8'h1E, "R2 readback", ctl_rdata, 8'h1E);
    wr_ctl(8'h00);
    chk(ctl_rdata == 8'h00, "R2 clear", ctl_rdata, 0);
  endtask

  task automatic t_m0_tx(input logic [7:0] d);
    logic [7:0] got;
    int last = 0;
    wr_ctl(mk(2'd0, 0, 0, 0));
    wr_buf(d);
    for (int i = 0; i < 8; i++) begin
      wait_txd_rise();
      got[i] = rxd_out;
      if (i == 0) chk(rxd_oe == 1'b1, "R3 oe", rxd_oe, 1);
      if (i > 0) chk(cyc - last == 12, "R3 period", cyc - last, 12);
      last = cyc;
    end
    chk(got == d, "R3 data", got, d);
    wait_bit(6, 100);
    chk(ctl_rdata[6] == 1'b1, "R3 tx_done", ctl_rdata[6], 1);
    chk(rxd_oe == 1'b0, "R3 oe idle", rxd_oe, 0);
    wr_ctl(8'h00);
  endtask

  task automatic t_m0_rx(input logic [7:0] d);
    rxd_in = d[0];
    wr_ctl(mk(2'd0, 0, 1, 0));
    for (int i = 1; i < 8; i++) begin
      wait_txd_rise();
      rxd_in = d[i];
    end
    wait_bit(7, 100);
    chk(ctl_rdata[7] == 1'b1, "R4 rx_done", ctl_rdata[7], 1);
    chk(rx_buf == d, "R4 data", rx_buf, d);
    wr_ctl(8'h00);
    rxd_in = 1'b1;
  endtask

  task automatic t_async_tx(input logic [1:0] m, input bit dbl, input logic [7:0] d,
                            input bit tb8, input int bitclk, input string tag);
    logic [10:0] got, exp;
    int nb, t0, w, dur;
    nb  = m[1] ? 11 : 10;
    exp = m[1] ? {1'b1, tb8, d, 1'b0} : {1'b1, 1'b1, d, 1'b0};
    rate_dbl = dbl;
    wr_ctl(mk(m, 0, 0, tb8));
    t0 = cyc;
    wr_buf(d);
    w = 0;
    while (txd !== 1'b0 && w < 100) begin @(negedge clk); w++; end
    repeat (bitclk / 2) @(negedge clk);
    got = '1;
    got[0] = txd;
    for (int k = 1; k < nb; k++) begin
      repeat (bitclk) @(negedge clk);
      got[k] = txd;
    end
    chk(got == exp, "R5 frame", got, exp);
    wait_bit(6, 4 * bitclk);
    dur = cyc - t0;
    chk(dur >= nb * bitclk - bitclk / 8 && dur <= nb * bitclk + bitclk / 8, tag, dur, nb * bitclk);
  endtask

  task automatic t_flag_hold();
    repeat (300) @(negedge clk);
    chk(ctl_rdata[6] == 1'b1, "R14 held", ctl_rdata[6], 1);
    wr_ctl(8'h00);
    chk(ctl_rdata[6] == 1'b0, "R14 cleared", ctl_rdata[6], 0);
  endtask

  task automatic t_rx_basic();
    rate_dbl = 1'b1;
    wr_ctl(mk(2'd3, 0, 1, 0));
    send_frame(8'h96, 1, 1, 1, 64);
    chk(rx_buf == 8'h96, "R8 m3 data", rx_buf, 8'h96);
    chk(ctl_rdata[7:5] == 3'b101, "R8 m3 flags", ctl_rdata[7:5], 3'b101);
    rate_dbl = 1'b0;
    wr_ctl(mk(2'd2, 0, 1, 0));
    send_frame(8'h4B, 1, 0, 1, 64);
    chk(rx_buf == 8'h4B, "R8 m2 data", rx_buf, 8'h4B);
    chk(ctl_rdata[7:5] == 3'b100, "R8 m2 flags", ctl_rdata[7:5], 3'b100);
    send_frame(8'h11, 1, 1, 1, 64);
    chk(rx_buf == 8'h4B, "R12 data kept", rx_buf, 8'h4B);
    chk(ctl_rdata[5] == 1'b0, "R12 b8 kept", ctl_rdata[5], 0);
  endtask

  task automatic t_rx_mask();
    rate_dbl = 1'b1;
    wr_ctl(mk(2'd3, 1, 1, 0));
    send_frame(8'h22, 1, 0, 1, 64);
    chk(ctl_rdata[7] == 1'b0, "R9 drop flag", ctl_rdata[7], 0);
    chk(rx_buf == 8'h4B, "R9 drop data", rx_buf, 8'h4B);
    send_frame(8'h33, 1, 1, 1, 64);
    chk(rx_buf == 8'h33, "R9 accept data", rx_buf, 8'h33);
    chk(ctl_rdata[7] == 1'b1, "R9 accept flag", ctl_rdata[7], 1);
  endtask

  task automatic t_rx_m1();
    rate_dbl = 1'b1;
    wr_ctl(mk(2'd1, 1, 1, 0));
    send_frame(8'h44, 0, 0, 0, 64);
    chk(ctl_rdata[7] == 1'b0, "R10 bad stop dropped", ctl_rdata[7], 0);
    chk(rx_buf == 8'h33, "R10 data kept", rx_buf, 8'h33);
    send_frame(8'h55, 0, 0, 1, 64);
    chk(rx_buf == 8'h55, "R10 good stop data", rx_buf, 8'h55);
    chk(ctl_rdata[7:5] == 3'b101, "R8 m1 flags", ctl_rdata[7:5], 3'b101);
    wr_ctl(mk(2'd1, 0, 1, 0));
    send_frame(8'h66, 0, 0, 0, 64);
    chk(rx_buf == 8'h66, "R10 unmasked data", rx_buf, 8'h66);
    chk(ctl_rdata[7:5] == 3'b100, "R8 m1 stop0 b8", ctl_rdata[7:5], 3'b100);
  endtask

  task automatic t_rx_disabled();
    rate_dbl = 1'b1;
    wr_ctl(mk(2'd3, 0, 0, 0));
    send_frame(8'h77, 1, 1, 1, 64);
    chk(ctl_rdata[7] == 1'b0, "R11 flag", ctl_rdata[7], 0);
    chk(rx_buf == 8'h66, "R11 data", rx_buf, 8'h66);
  endtask

  task automatic t_false_start();
    rate_dbl = 1'b1;
    wr_ctl(mk(2'd2, 0, 1, 0));
    @(negedge clk); rxd_in = 1'b0;
    repeat (6) @(negedge clk);
    rxd_in = 1'b1;
    repeat (400) @(negedge clk);
    chk(ctl_rdata[7] == 1'b0, "R13 glitch no frame", ctl_rdata[7], 0);
    chk(rx_buf == 8'h66, "R13 glitch data", rx_buf, 8'h66);
    send_frame(8'h5A, 1, 1, 1, 32);
    chk(rx_buf == 8'h5A, "R13 recovery", rx_buf, 8'h5A);
    wr_ctl(8'h00);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ctl();
    t_m0_tx(8'hA5);
    t_m0_rx(8'h3C);
    t_async_tx(2'd2, 1'b1, 8'hC3, 1'b1, 32, "R6 fast");
    t_flag_hold();
    t_async_tx(2'd2, 1'b0, 8'h5A, 1'b0, 64, "R6 slow");
    t_async_tx(2'd1, 1'b1, 8'h81, 1'b0, 64, "R7 dbl");
    t_async_tx(2'd1, 1'b0, 8'h3E, 1'b0, 128, "R7 half");
    t_async_tx(2'd3, 1'b1, 8'h0F, 1'b1, 64, "R7 m3");
    t_rx_basic();
    t_rx_mask();
    t_rx_m1();
    t_rx_disabled();
    t_false_start();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule